// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits between a set of interrupt request lines and an 8-bit processor core. It takes five request inputs and picks one of them by fixed priority. The inputs are a non-maskable line, three vectored lines that each have their own mask bit (A and B are level-sensitive, C is edge-latched), and one general line. It then offers the winner to the core as a pending flag together with a 16-bit vector address. The general line has no fixed vector, so for it the block raises an external-vector indication instead.

The core finishes its current instruction before taking an interrupt. The block therefore samples the request lines only on the cycle the core pulses the instruction-end strobe. The offer behaves like a valid/ready handshake. The pending flag acts as valid and the acknowledge acts as ready. Once raised, the pending flag, the vector and the external indication hold still until the core acknowledges them, whatever the request lines do in the meantime, and no new offer is formed while one is held.

Software can set and clear a global enable and write the three mask bits through a set-mask strobe that carries an update bit and a clear bit for the C latch. It reads everything back through a status word, which lets it save and restore masks to change the nesting order during service.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset the pending flag and external indication are 0, the global enable is 0, all three mask bits are 1 (blocked), and the status word reads 0x07.
- R2: When several requests are eligible at the same sampling point, the winner follows this order, highest first: non-maskable, C, B, A, general.
- R3: The offered vector is 0x0024 for the non-maskable line, 0x002C for A, 0x0034 for B and 0x003C for C. For the general line the vector is 0x0000 and the external indication is 1.
- R4: An offer is formed only on a cycle where insn_end is 1, no offer is held and a request is eligible. The pending flag rises on the following cycle.
- R5: While the pending flag is 1 and ack is 0, the flag, vector and external indication do not change. A cycle with ack=1 while pending drops the flag on the next cycle.
- R6: With the global enable at 0, only the non-maskable line can produce an offer. en_set sets the enable, en_clr clears it, and en_clr wins when both are given.
- R7: Acknowledging any offer other than the non-maskable one clears the global enable, and this takes precedence over en_set in the same cycle.
- R8: A mask write (mask_wdata bit 3 = 1) loads bits 2:0 into the mask bits of A, B and C, whatever the global enable. With bit 3 = 0 the mask bits are kept. A line whose mask bit is 1 is never offered.
- R9: A rising edge on edge_c_in sets a latch that stays set after the line falls. The latch clears when a C offer is acknowledged, or on a mask write with mask_wdata bit 4 = 1.
- R10: Lines A and B are offered only if they are high on the sampling cycle.
- R11: The non-maskable line is offered only after a rising edge while it is still high. After its acknowledge it cannot fire again until it has gone low and risen again.
- R12: Status bits: [2:0] mask A/B/C, [3] global enable, [4] level of A, [5] level of B, [6] C latch, [7] non-maskable latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request |
| lvl_a_in | input | 1 | Level request A |
| lvl_b_in | input | 1 | Level request B |
| edge_c_in | input | 1 | Edge request C |
| gen_in | input | 1 | General request (external vector) |
| insn_end | input | 1 | Instruction-end strobe from the core |
| ack | input | 1 | Core accepts the held offer |
| en_set | input | 1 | Set global enable |
| en_clr | input | 1 | Clear global enable |
| mask_wr | input | 1 | Set-mask write strobe |
| mask_wdata | input | 5 | [2:0] mask A/B/C, [3] mask update, [4] clear C latch |
| irq_pend | output | 1 | Offer valid |
| irq_vec | output | 16 | Vector of the held offer |
| irq_ext | output | 1 | Held offer needs an external vector |
| status | output | 8 | Readback word |

## Verification
The assertions check on every cycle that an offer only appears after an instruction-end strobe, that a held offer stays frozen until acknowledged and then drops, and that an offer formed with the enable cleared can only be the non-maskable vector. They also check that accepting a maskable or general offer turns the enable off, that a mask write without the update bit leaves the masks alone, and that the external indication only comes with a zero vector. The bench scenarios cover what depends on stimulus history. These are the priority order among simultaneous requests, the C latch surviving its line falling and its two clear paths, and the rule that the non-maskable line must fall and rise again before it can refire.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int NUM_MASK  = 3;
  localparam int NUM_SRC   = NUM_MASK + 2;
  localparam int VEC_W     = 16;
  localparam int MWD_W     = NUM_MASK + 2;
  localparam int STAT_W    = 2 * NUM_MASK + 2;
  localparam int UPD_BIT   = NUM_MASK;
  localparam int CLRC_BIT  = NUM_MASK + 1;
  localparam logic [VEC_W-1:0] VEC_BASE = 16'h0024;
  localparam int VEC_STEP  = 8;

  typedef enum logic [2:0] {
    SRC_GEN = 3'd0,
    SRC_A   = 3'd1,
    SRC_B   = 3'd2,
    SRC_C   = 3'd3,
    SRC_NMI = 3'd4
  } irq_src_e;

  function automatic logic [VEC_W-1:0] vec_of(irq_src_e s);
    logic [VEC_W-1:0] v;
    case (s)
      SRC_GEN: v = '0;
      SRC_NMI: v = VEC_BASE;
      default: v = VEC_BASE + VEC_W'(VEC_STEP * int'(s));
    endcase
    return v;
  endfunction
endpackage

// File: rtl/irqc_edge_latch.sv
module irqc_edge_latch #(
  parameter bit DROP_WHEN_LOW = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic lat
);
  logic din_q;
  logic rise;

  assign rise = din & ~din_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q <= 1'b0;
      lat   <= 1'b0;
    end else begin
      din_q <= din;
      if (rise)
        lat <= 1'b1;
      else if (clr)
        lat <= 1'b0;
      else if (DROP_WHEN_LOW && !din)
        lat <= 1'b0;
    end
  end
endmodule

// File: rtl/irqc_ctrl_regs.sv
module irqc_ctrl_regs import irqc_pkg::*; (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mask_wr,
  input  logic [MWD_W-1:0]    mask_wdata,
  input  logic                en_set,
  input  logic                en_clr,
  input  logic                auto_dis,
  output logic [NUM_MASK-1:0] mask,
  output logic                gl_en
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask  <= '1;
      gl_en <= 1'b0;
    end else begin
      if (mask_wr && mask_wdata[UPD_BIT])
        mask <= mask_wdata[NUM_MASK-1:0];
      if (en_clr || auto_dis)
        gl_en <= 1'b0;
      else if (en_set)
        gl_en <= 1'b1;
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter import irqc_pkg::*; (
  input  logic [NUM_SRC-1:0] req,
  output logic               any,
  output irq_src_e           sel
);
  always_comb begin
    sel = SRC_GEN;
    for (int i = 0; i < NUM_SRC; i++)
      if (req[i]) sel = irq_src_e'(3'(i));
    any = |req;
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl import irqc_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              lvl_a_in,
  input  logic              lvl_b_in,
  input  logic              edge_c_in,
  input  logic              gen_in,
  input  logic              insn_end,
  input  logic              ack,
  input  logic              en_set,
  input  logic              en_clr,
  input  logic              mask_wr,
  input  logic [MWD_W-1:0]  mask_wdata,
  output logic              irq_pend,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              irq_ext,
  output logic [STAT_W-1:0] status
);
  logic                nmi_lat;
  logic                c_lat;
  logic [NUM_MASK-1:0] mask;
  logic                gl_en;
  logic [NUM_SRC-1:0]  req;
  logic                any_req;
  irq_src_e            win;
  irq_src_e            held_src;
  logic                take;
  logic                clr_c;
  logic                clr_nmi;
  logic                auto_dis;
  logic [NUM_MASK-1:0] mline;

  assign take     = irq_pend & ack;
  assign clr_c    = (take && held_src == SRC_C) || (mask_wr && mask_wdata[CLRC_BIT]);
  assign clr_nmi  = take && held_src == SRC_NMI;
  assign auto_dis = take && held_src != SRC_NMI;
  assign mline    = {c_lat, lvl_b_in, lvl_a_in};

  irqc_edge_latch #(.DROP_WHEN_LOW(1'b1)) u_nmi_lat (
    .clk(clk), .rst_n(rst_n), .din(nmi_in), .clr(clr_nmi), .lat(nmi_lat));

  irqc_edge_latch #(.DROP_WHEN_LOW(1'b0)) u_c_lat (
    .clk(clk), .rst_n(rst_n), .din(edge_c_in), .clr(clr_c), .lat(c_lat));

  irqc_ctrl_regs u_regs (
    .clk(clk), .rst_n(rst_n), .mask_wr(mask_wr), .mask_wdata(mask_wdata),
    .en_set(en_set), .en_clr(en_clr), .auto_dis(auto_dis),
    .mask(mask), .gl_en(gl_en));

  assign req[SRC_GEN] = gl_en & gen_in;
  assign req[SRC_NMI] = nmi_lat & nmi_in;
  for (genvar g = 0; g < NUM_MASK; g++) begin : g_mreq
    assign req[g + 1] = gl_en & mline[g] & ~mask[g];
  end

  irqc_arbiter u_arb (.req(req), .any(any_req), .sel(win));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_pend <= 1'b0;
      irq_ext  <= 1'b0;
      irq_vec  <= '0;
      held_src <= SRC_GEN;
    end else if (take) begin
      irq_pend <= 1'b0;
      irq_ext  <= 1'b0;
    end else if (!irq_pend && insn_end && any_req) begin
      irq_pend <= 1'b1;
      irq_ext  <= (win == SRC_GEN);
      irq_vec  <= vec_of(win);
      held_src <= win;
    end
  end

  assign status = {nmi_lat, c_lat, lvl_b_in, lvl_a_in, gl_en, mask};
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker import irqc_pkg::*; (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_end,
  input logic              ack,
  input logic              mask_wr,
  input logic [MWD_W-1:0]  mask_wdata,
  input logic              irq_pend,
  input logic [VEC_W-1:0]  irq_vec,
  input logic              irq_ext,
  input logic [STAT_W-1:0] status
);
  // R4
  offer_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pend) |-> $past(insn_end));

  // R5
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && !ack) |=> (irq_pend && $stable(irq_vec) && $stable(irq_ext)));

  // R5
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && ack) |=> !irq_pend);

  // R6
  disabled_only_nmi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(irq_pend) && !$past(status[3])) |-> (irq_vec == VEC_BASE));

  // R7
  auto_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_pend && ack && irq_vec != VEC_BASE) |=> !status[3]);

  // R8
  mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_wr && !mask_wdata[UPD_BIT]) |=> $stable(status[NUM_MASK-1:0]));

  // R3
  ext_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext |-> (irq_pend && irq_vec == '0));
endmodule

bind prio_irq_ctrl irqc_checker u_chk (.*);

// File: tb/test_prio_irq_ctrl.sv
module test_prio_irq_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_in = 0, lvl_a_in = 0, lvl_b_in = 0, edge_c_in = 0, gen_in = 0;
  logic insn_end = 0, ack = 0, en_set = 0, en_clr = 0, mask_wr = 0;
  logic [4:0]  mask_wdata = '0;
  logic        irq_pend, irq_ext;
  logic [15:0] irq_vec;
  logic [7:0]  status;
  int total = 0, bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .lvl_a_in(lvl_a_in),
    .lvl_b_in(lvl_b_in), .edge_c_in(edge_c_in), .gen_in(gen_in),
    .insn_end(insn_end), .ack(ack), .en_set(en_set), .en_clr(en_clr),
    .mask_wr(mask_wr), .mask_wdata(mask_wdata), .irq_pend(irq_pend),
    .irq_vec(irq_vec), .irq_ext(irq_ext), .status(status));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic enable_on();
    en_set = 1; cyc(); en_set = 0;
  endtask

  task automatic write_mask(logic [4:0] d);
    mask_wr = 1; mask_wdata = d; cyc(); mask_wr = 0; mask_wdata = '0;
  endtask

  task automatic offer();
    insn_end = 1; cyc(); insn_end = 0;
  endtask

  task automatic accept();
    ack = 1; cyc(); ack = 0;
  endtask

  task automatic t_reset();
    chk("R1 pend", irq_pend, 0);
    chk("R1 ext", irq_ext, 0);
    chk("R1 R12 status", status, 8'h07);
  endtask

  task automatic t_enable_and_mask();
    enable_on();
    chk("R6 en_set", status[3], 1);
    en_set = 1; en_clr = 1; cyc(); en_set = 0; en_clr = 0;
    chk("R6 clr wins", status[3], 0);
    write_mask(5'b01000);
    chk("R8 write with enable off", status[2:0], 0);
    write_mask(5'b00111);
    chk("R8 no update bit", status[2:0], 0);
  endtask

  task automatic t_level_a();
    enable_on();
    lvl_a_in = 1; cyc();
    chk("R12 level A bit", status[4], 1);
    offer();
    chk("R10 A pend", irq_pend, 1);
    chk("R3 A vec", irq_vec, 16'h002C);
    chk("R3 A ext", irq_ext, 0);
    en_set = 1; accept(); en_set = 0;
    chk("R5 drop", irq_pend, 0);
    chk("R7 auto disable", status[3], 0);
    offer();
    chk("R6 blocked", irq_pend, 0);
    write_mask(5'b01001);
    enable_on();
    offer();
    chk("R8 masked A", irq_pend, 0);
    write_mask(5'b01000);
    lvl_a_in = 0; cyc();
    offer();
    chk("R10 A low", irq_pend, 0);
    en_clr = 1; cyc(); en_clr = 0;
  endtask

  task automatic t_priority();
    enable_on();
    lvl_a_in = 1; lvl_b_in = 1; gen_in = 1; cyc();
    offer();
    chk("R2 B first", irq_vec, 16'h0034);
    accept(); enable_on(); lvl_b_in = 0; cyc();
    offer();
    chk("R2 A next", irq_vec, 16'h002C);
    accept(); enable_on(); lvl_a_in = 0; cyc();
    offer();
    chk("R2 general pend", irq_pend, 1);
    chk("R3 general vec", irq_vec, 16'h0000);
    chk("R3 general ext", irq_ext, 1);
    accept(); gen_in = 0; cyc();
    chk("R5 ext drop", irq_ext, 0);
  endtask

  task automatic t_hold_and_boundary();
    enable_on();
    lvl_b_in = 1; cyc(3);
    chk("R4 no strobe", irq_pend, 0);
    offer();
    chk("R4 strobe", irq_vec, 16'h0034);
    lvl_b_in = 0; lvl_a_in = 1; cyc(2);
    offer();
    chk("R5 held pend", irq_pend, 1);
    chk("R5 held vec", irq_vec, 16'h0034);
    accept(); lvl_a_in = 0; cyc();
  endtask

  task automatic t_edge_c();
    enable_on();
    edge_c_in = 1; cyc(); edge_c_in = 0; cyc();
    chk("R9 latch held", status[6], 1);
    lvl_a_in = 1; lvl_b_in = 1; cyc();
    offer();
    chk("R2 C over B", irq_vec, 16'h003C);
    accept(); lvl_a_in = 0; lvl_b_in = 0; cyc();
    chk("R9 ack clears", status[6], 0);
    write_mask(5'b01100);
    enable_on();
    edge_c_in = 1; cyc(); edge_c_in = 0; cyc();
    offer();
    chk("R8 masked C", irq_pend, 0);
    chk("R9 masked still latched", status[6], 1);
    write_mask(5'b10100);
    chk("R9 clear bit", status[6], 0);
    chk("R8 mask kept on clear", status[2:0], 3'b100);
    write_mask(5'b01000);
    en_clr = 1; cyc(); en_clr = 0;
  endtask

  task automatic t_nmi();
    nmi_in = 1; cyc(2);
    chk("R12 nmi bit", status[7], 1);
    lvl_b_in = 1; enable_on();
    offer();
    chk("R11 R2 nmi first", irq_vec, 16'h0024);
    accept();
    chk("R6 nmi keeps enable", status[3], 1);
    en_clr = 1; cyc(); en_clr = 0; lvl_b_in = 0;
    offer();
    chk("R11 no refire", irq_pend, 0);
    nmi_in = 0; cyc(); nmi_in = 1; cyc();
    offer();
    chk("R6 R11 refire disabled", irq_vec, 16'h0024);
    chk("R11 refire pend", irq_pend, 1);
    accept(); nmi_in = 0; cyc();
    nmi_in = 1; cyc(); nmi_in = 0; cyc();
    offer();
    chk("R11 gone low", irq_pend, 0);
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc();
    t_reset();
    t_enable_and_mask();
    t_level_a();
    t_priority();
    t_hold_and_boundary();
    t_edge_c();
    t_nmi();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule